// File: doc/BRIEF.md
# Receive Status Read Gate

This block sits between a receive FIFO and the host's register port. At the end of every received frame it captures a 32-bit frame status record. When a record becomes the current one, it raises a receive interrupt. The host takes the record out one byte per read, through a single status address. While a record is waiting, ordinary FIFO data reads are held back and get no data-valid acknowledge, so the host cannot read past a frame boundary before it has consumed that frame's status.

A mode input lets the host take the status in-line through the data address instead. In that mode, data reads made while a record is waiting return the status bytes in order. A second record that arrives while the first is still unread is parked in a one-entry pending slot. That slot moves into the status location when the fourth byte of the current record is taken. The FIFO data-request output always follows FIFO occupancy, whatever the state of the status record.

Top module: `rx_status_gate`

## Requirements
- R1: After reset, rx_irq is 0, no status record is valid and host_dtv is 0.
- R2: rx_dreq equals the inverse of fifo_empty at all times, whatever the status record state.
- R3: A frame_end pulse while no record is valid makes that record current, and rx_irq is 1 in the following cycle.
- R4: A read with host_sel=2'b01 while a record is valid returns the record's bytes least significant first (bits 7:0, then 15:8, 23:16, 31:24), one byte per read, with host_dtv=1 in the cycle after the read strobe. The record becomes invalid after the fourth read.
- R5: A read with host_sel=2'b01 while no record is valid gives host_dtv=0 and changes no state.
- R6: With inline_mode=0, a read with host_sel=2'b00 while a record is valid gives host_dtv=0 and does not assert fifo_rd.
- R7: With inline_mode=1, a read with host_sel=2'b00 while a record is valid returns the next status byte, in the same order as R4, with host_dtv=1 and without asserting fifo_rd.
- R8: A read with host_sel=2'b00 while no record is valid and fifo_empty=0 asserts fifo_rd in the same cycle and returns fifo_rdata with host_dtv=1 one cycle later. If fifo_empty=1, neither fifo_rd nor host_dtv is asserted.
- R9: A read with host_sel=2'b10 returns rx_irq in bit 0, with the other bits 0 and host_dtv=1, and clears rx_irq. If a record becomes current in the same cycle, rx_irq stays 1.
- R10: A frame_end pulse while a record is valid and the pending slot is empty is held. After the fourth byte of the current record is read, the held record becomes current and rx_irq is set again.
- R11: A frame_end pulse while both the current record and the pending slot are full is discarded.
- R12: If frame_end and the fourth status read happen in the same cycle and the pending slot is empty, the new record becomes current at once and rx_irq is set.
- R13: A read with host_sel=2'b11 gives host_dtv=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| inline_mode | input | 1 | 1: data-address reads deliver a waiting status record |
| frame_end | input | 1 | One-cycle strobe: a frame has ended |
| frame_stat | input | 32 | Status record for the frame, valid with frame_end |
| fifo_rdata | input | 8 | Head byte of the receive FIFO |
| fifo_empty | input | 1 | Receive FIFO holds no data |
| fifo_rd | output | 1 | Pop the FIFO head (same cycle as the honored read) |
| host_rd | input | 1 | Host read strobe |
| host_sel | input | 2 | Read address: 00 data, 01 status, 10 interrupt, 11 unused |
| host_rdata | output | 8 | Read data, one cycle after the strobe |
| host_dtv | output | 1 | Read honored, qualifies host_rdata |
| rx_dreq | output | 1 | Receive data request, follows FIFO occupancy |
| rx_irq | output | 1 | Receive interrupt: a status record became current |

## Verification
Two collisions matter here. The first is the fourth status read landing in the same cycle as a new frame_end. The second is an interrupt-register read landing in the same cycle as a record becoming current. The bench drives each pair in one clock cycle. For the first pair, it judges whether the new record's bytes come back next. For the second, it judges whether rx_irq survives the clearing read. A scoreboard queue holds the expected acknowledge and byte for each read, as predicted by an independent record-queue model. A monitor compares these one cycle after each strobe.

// File: rtl/rx_stat_pkg.sv
package rx_stat_pkg;
  localparam int BYTE_W     = 8;
  localparam int STAT_BYTES = 4;
  localparam int STAT_W     = BYTE_W * STAT_BYTES;
  localparam int IDX_W      = $clog2(STAT_BYTES);
  localparam int IRQ_BIT    = 0;

  typedef logic [STAT_W-1:0] stat_t;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [1:0] {
    SEL_DATA = 2'b00,
    SEL_STAT = 2'b01,
    SEL_IRQ  = 2'b10,
    SEL_NONE = 2'b11
  } host_sel_e;

  // Byte at read position idx, least significant byte first
  function automatic byte_t stat_byte(input stat_t rec, input logic [IDX_W-1:0] idx);
    stat_t shifted;
    shifted = rec >> (int'(idx) * BYTE_W);
    return shifted[BYTE_W-1:0];
  endfunction

  // Is idx the last byte position of a record
  function automatic logic is_last_pos(input logic [IDX_W-1:0] idx);
    return idx == IDX_W'(STAT_BYTES - 1);
  endfunction

  // Interrupt register image
  function automatic byte_t irq_image(input logic irq);
    byte_t img;
    img = '0;
    img[IRQ_BIT] = irq;
    return img;
  endfunction
endpackage

// File: rtl/rx_stat_store.sv
module rx_stat_store
  import rx_stat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_stb,
  input  stat_t            cap_rec,
  input  logic             consume,
  output logic             stat_valid,
  output logic             pend_valid,
  output logic [IDX_W-1:0] rd_idx,
  output byte_t            cur_byte,
  output logic             rec_done,
  output logic             load_evt
);
  stat_t cur_q;
  stat_t pend_q;
  logic  take;

  assign take     = consume && stat_valid;
  assign rec_done = take && is_last_pos(rd_idx);
  assign cur_byte = stat_byte(cur_q, rd_idx);

  // A record becomes current: fresh capture into an empty slot, or a refill at record end
  always_comb load_evt = (cap_stb && !stat_valid) || (rec_done && (pend_valid || cap_stb));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q      <= '0;
      pend_q     <= '0;
      stat_valid <= 1'b0;
      pend_valid <= 1'b0;
      rd_idx     <= '0;
    end else if (rec_done) begin
      rd_idx <= '0;
      if (pend_valid) begin
        cur_q      <= pend_q;
        pend_valid <= cap_stb;
        if (cap_stb) pend_q <= cap_rec;
      end else if (cap_stb) begin
        cur_q <= cap_rec;
      end else begin
        stat_valid <= 1'b0;
      end
    end else begin
      if (take) rd_idx <= rd_idx + 1'b1;
      if (cap_stb) begin
        if (!stat_valid) begin
          cur_q      <= cap_rec;
          stat_valid <= 1'b1;
        end else if (!pend_valid) begin
          pend_q     <= cap_rec;
          pend_valid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rx_read_arb.sv
module rx_read_arb
  import rx_stat_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_rd,
  input  logic [1:0] host_sel,
  input  logic       inline_mode,
  input  logic       stat_valid,
  input  byte_t      cur_byte,
  input  logic       fifo_empty,
  input  byte_t      fifo_rdata,
  input  logic       irq,
  output logic       consume,
  output logic       fifo_rd,
  output logic       irq_read,
  output byte_t      rdata,
  output logic       dtv
);
  logic  dtv_n;
  byte_t data_n;

  always_comb begin
    consume  = 1'b0;
    fifo_rd  = 1'b0;
    irq_read = 1'b0;
    dtv_n    = 1'b0;
    data_n   = '0;
    if (host_rd) begin
      case (host_sel_e'(host_sel))
        SEL_DATA: begin
          if (stat_valid) begin
            if (inline_mode) begin
              consume = 1'b1;
              dtv_n   = 1'b1;
              data_n  = cur_byte;
            end
          end else if (!fifo_empty) begin
            fifo_rd = 1'b1;
            dtv_n   = 1'b1;
            data_n  = fifo_rdata;
          end
        end
        SEL_STAT: begin
          if (stat_valid) begin
            consume = 1'b1;
            dtv_n   = 1'b1;
            data_n  = cur_byte;
          end
        end
        SEL_IRQ: begin
          irq_read = 1'b1;
          dtv_n    = 1'b1;
          data_n   = irq_image(irq);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dtv   <= 1'b0;
      rdata <= '0;
    end else begin
      dtv   <= dtv_n;
      rdata <= data_n;
    end
  end
endmodule

// File: rtl/rx_irq_flag.sv
module rx_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  output logic irq
);
  // Set has priority over clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq <= 1'b0;
    else if (set_evt) irq <= 1'b1;
    else if (clr_evt) irq <= 1'b0;
  end
endmodule

// File: rtl/rx_status_gate.sv
module rx_status_gate
  import rx_stat_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inline_mode,
  input  logic        frame_end,
  input  logic [31:0] frame_stat,
  input  logic [7:0]  fifo_rdata,
  input  logic        fifo_empty,
  output logic        fifo_rd,
  input  logic        host_rd,
  input  logic [1:0]  host_sel,
  output logic [7:0]  host_rdata,
  output logic        host_dtv,
  output logic        rx_dreq,
  output logic        rx_irq
);
  logic             stat_valid;
  logic             pend_valid;
  logic [IDX_W-1:0] rd_idx;
  byte_t            cur_byte;
  logic             rec_done;
  logic             load_evt;
  logic             consume;
  logic             irq_read;

  assign rx_dreq = !fifo_empty;

  rx_stat_store u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_stb    (frame_end),
    .cap_rec    (frame_stat),
    .consume    (consume),
    .stat_valid (stat_valid),
    .pend_valid (pend_valid),
    .rd_idx     (rd_idx),
    .cur_byte   (cur_byte),
    .rec_done   (rec_done),
    .load_evt   (load_evt)
  );

  rx_read_arb u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_rd     (host_rd),
    .host_sel    (host_sel),
    .inline_mode (inline_mode),
    .stat_valid  (stat_valid),
    .cur_byte    (cur_byte),
    .fifo_empty  (fifo_empty),
    .fifo_rdata  (fifo_rdata),
    .irq         (rx_irq),
    .consume     (consume),
    .fifo_rd     (fifo_rd),
    .irq_read    (irq_read),
    .rdata       (host_rdata),
    .dtv         (host_dtv)
  );

  rx_irq_flag u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (load_evt),
    .clr_evt (irq_read),
    .irq     (rx_irq)
  );
endmodule

// File: rtl/rx_status_gate_chk.sv
module rx_status_gate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_rd,
  input logic [1:0] host_sel,
  input logic       frame_end,
  input logic       fifo_empty,
  input logic       fifo_rd,
  input logic       host_dtv,
  input logic       rx_irq,
  input logic       stat_valid,
  input logic       load_evt,
  input logic       irq_read
);
  // R6
  no_pop_with_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> !fifo_rd);

  // R8
  pop_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> (!fifo_empty && host_rd && host_sel == 2'b00));

  // R5
  stat_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_sel == 2'b01 && !stat_valid) |=> !host_dtv);

  // R3
  first_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !stat_valid) |=> (stat_valid && rx_irq));

  // R9
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_read && !load_evt) |=> !rx_irq);

  // R13
  unused_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_sel == 2'b11) |=> !host_dtv);
endmodule

bind rx_status_gate rx_status_gate_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_rd    (host_rd),
  .host_sel   (host_sel),
  .frame_end  (frame_end),
  .fifo_empty (fifo_empty),
  .fifo_rd    (fifo_rd),
  .host_dtv   (host_dtv),
  .rx_irq     (rx_irq),
  .stat_valid (stat_valid),
  .load_evt   (load_evt),
  .irq_read   (irq_read)
);

// File: tb/rx_status_gate_test.sv
module rx_status_gate_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inline_mode = 1'b0;
  logic        frame_end = 1'b0;
  logic [31:0] frame_stat = '0;
  logic [7:0]  fifo_rdata = 8'hA5;
  logic        fifo_empty = 1'b0;
  logic        fifo_rd;
  logic        host_rd = 1'b0;
  logic [1:0]  host_sel = 2'b00;
  logic [7:0]  host_rdata;
  logic        host_dtv;
  logic        rx_dreq;
  logic        rx_irq;

  always #5 clk = ~clk;

  rx_status_gate uut (
    .clk(clk), .rst_n(rst_n), .inline_mode(inline_mode),
    .frame_end(frame_end), .frame_stat(frame_stat),
    .fifo_rdata(fifo_rdata), .fifo_empty(fifo_empty), .fifo_rd(fifo_rd),
    .host_rd(host_rd), .host_sel(host_sel), .host_rdata(host_rdata),
    .host_dtv(host_dtv), .rx_dreq(rx_dreq), .rx_irq(rx_irq)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  typedef struct {
    logic       dtv;
    logic [7:0] data;
    string      req;
  } exp_t;
  exp_t exq[$];

  // Independent model: queue of up to two records, byte cursor, interrupt
  logic [31:0] mq[$];
  int          m_pos = 0;
  logic        m_irq = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Monitor: compare each response one cycle after its strobe
  initial begin
    forever begin
      logic was_rd;
      exp_t e;
      @(posedge clk);
      was_rd = host_rd;
      #1;
      if (was_rd && exq.size() > 0) begin
        e = exq.pop_front();
        check(host_dtv == e.dtv, e.req, "dtv", 32'(host_dtv), 32'(e.dtv));
        if (e.dtv)
          check(host_rdata == e.data, e.req, "rdata", 32'(host_rdata), 32'(e.data));
      end
    end
  end

  // One read, optionally with a frame end in the same cycle
  task automatic do_read(input logic [1:0] sel, input bit with_frame,
                         input logic [31:0] fval, input string req);
    exp_t e;
    bit   exp_pop;
    bit   loaded;
    bit   was_empty;
    @(negedge clk);
    host_sel   = sel;
    host_rd    = 1'b1;
    frame_end  = with_frame;
    frame_stat = fval;
    e.dtv = 1'b0; e.data = 8'h00; e.req = req; exp_pop = 0; loaded = 0;
    if (sel == 2'b01 || (sel == 2'b00 && inline_mode && mq.size() > 0)) begin
      if (mq.size() > 0) begin
        e.dtv  = 1'b1;
        e.data = mq[0][m_pos*8 +: 8];
        m_pos++;
        if (m_pos == 4) begin
          m_pos = 0;
          void'(mq.pop_front());
          if (mq.size() > 0) loaded = 1;
        end
      end
    end else if (sel == 2'b00) begin
      if (mq.size() == 0 && !fifo_empty) begin
        e.dtv = 1'b1; e.data = fifo_rdata; exp_pop = 1;
      end
    end else if (sel == 2'b10) begin
      e.dtv = 1'b1; e.data = {7'b0, m_irq};
    end
    was_empty = (mq.size() == 0);
    if (with_frame && mq.size() < 2) begin
      mq.push_back(fval);
      if (was_empty) loaded = 1;
    end
    exq.push_back(e);
    #1;
    check(fifo_rd == exp_pop, req, "fifo_rd", 32'(fifo_rd), 32'(exp_pop));
    m_irq = loaded ? 1'b1 : ((sel == 2'b10) ? 1'b0 : m_irq);
    @(negedge clk);
    host_rd   = 1'b0;
    frame_end = 1'b0;
  endtask

  task automatic do_frame(input logic [31:0] fval);
    @(negedge clk);
    frame_end  = 1'b1;
    frame_stat = fval;
    if (mq.size() < 2) begin
      if (mq.size() == 0) m_irq = 1'b1;
      mq.push_back(fval);
    end
    @(negedge clk);
    frame_end = 1'b0;
  endtask

  task automatic chk_irq(input string req);
    check(rx_irq == m_irq, req, "rx_irq", 32'(rx_irq), 32'(m_irq));
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(rx_irq == 1'b0, "R1", "rx_irq", 32'(rx_irq), 0);
    check(host_dtv == 1'b0, "R1", "host_dtv", 32'(host_dtv), 0);
    // R2 data request follows occupancy
    check(rx_dreq == 1'b1, "R2", "rx_dreq", 32'(rx_dreq), 1);
    fifo_empty = 1'b1; #1;
    check(rx_dreq == 1'b0, "R2", "rx_dreq", 32'(rx_dreq), 0);
    fifo_empty = 1'b0;

    do_read(2'b01, 0, 0, "R5");              // status read with nothing valid
    do_read(2'b00, 0, 0, "R8");              // FIFO byte A5
    fifo_rdata = 8'h3C;
    do_read(2'b00, 0, 0, "R8");              // second pattern
    fifo_empty = 1'b1;
    do_read(2'b00, 0, 0, "R8");              // empty: ignored
    fifo_empty = 1'b0;
    do_read(2'b11, 0, 0, "R13");

    do_frame(32'h4433_2211);                 // R3
    chk_irq("R3");
    do_read(2'b10, 0, 0, "R9");              // returns 1, clears
    chk_irq("R9");
    do_read(2'b00, 0, 0, "R6");              // blocked, no pop
    check(rx_dreq == 1'b1, "R2", "rx_dreq while status held", 32'(rx_dreq), 1);
    for (int i = 0; i < 4; i++) do_read(2'b01, 0, 0, "R4");
    do_read(2'b01, 0, 0, "R5");              // record consumed
    do_read(2'b00, 0, 0, "R8");              // FIFO readable again

    // R10 / R11: current, pending, and a discarded third record
    do_frame(32'hA1A2_A3A4);
    do_frame(32'hB1B2_B3B4);
    do_frame(32'hC1C2_C3C4);
    do_read(2'b10, 0, 0, "R9");
    chk_irq("R9");
    inline_mode = 1'b1;
    for (int i = 0; i < 4; i++) do_read(2'b00, 0, 0, "R7");
    chk_irq("R10");
    for (int i = 0; i < 4; i++) do_read(2'b00, 0, 0, "R10");
    do_read(2'b01, 0, 0, "R11");             // third record was dropped
    inline_mode = 1'b0;
    do_read(2'b10, 0, 0, "R9");

    // R12: fourth read and frame end in one cycle
    do_frame(32'h0D0C_0B0A);
    do_read(2'b10, 0, 0, "R9");
    for (int i = 0; i < 3; i++) do_read(2'b01, 0, 0, "R4");
    do_read(2'b01, 1, 32'h5566_7788, "R12");
    chk_irq("R12");
    for (int i = 0; i < 4; i++) do_read(2'b01, 0, 0, "R12");
    do_read(2'b01, 0, 0, "R12");

    // R9: clearing read coinciding with a new record
    do_read(2'b10, 1, 32'h1234_5678, "R9");
    chk_irq("R9");
    for (int i = 0; i < 4; i++) do_read(2'b01, 0, 0, "R4");

    repeat (3) @(negedge clk);
    check(exq.size() == 0, "R4", "scoreboard drained", 32'(exq.size()), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule